// File: doc/BRIEF.md
# IPv4 Reply Header Processor

This block sits between an Ethernet framing stage and a transport handler. It works on IPv4 headers carried as 32-bit words. On the receive side it takes a word stream made of a fixed 20-byte header (five words) followed by payload words. It checks the header's version, header length, checksum and protocol. The payload of a header that passes all four checks goes to the transport output unchanged. Every other packet is consumed and thrown away.

The last header that passed is kept. When the transport handler asks for a reply header and supplies the reply payload length, the block reflects the kept header. The two addresses trade places, the total length becomes the payload length plus 20, the time-to-live is set to a fixed value and a new header checksum goes into word 2. The five reply words leave on a separate output stream. All four streams use a valid/ready handshake, so either side can stall without losing a word.

Top module: `ipr_hdr_proc`

## Requirements
- R1: After reset, tp_valid and hd_valid are low, and rq_ready stays low until a header has been accepted.
- R2: A header is accepted when all of these hold: version (word 0 bits 31:28) is 4, header length (word 0 bits 27:24) is 5, protocol (word 2 bits 23:16) is 6, and the checksum over the five words is good. The payload words that follow an accepted header appear on tp_data in order and unchanged, with tp_last copying rx_last. Header words are never forwarded.
- R3: A packet whose protocol is not 6 is consumed with rx_ready held high and produces nothing on the transport output.
- R4: A packet with a version other than 4, a header length other than 5, or a bad header checksum is consumed and produces nothing on the transport output. A checksum is good when the ones'-complement sum of the ten 16-bit halves is 0xFFFF.
- R5: A packet that ends (rx_last) before its fifth word is dropped, and the next word is taken as word 0 of a new header.
- R6: A reply is exactly five words with hd_last on the fifth. Reply word 3 is the received word 4 (destination), and reply word 4 is the received word 3 (source).
- R7: Reply word 0 holds 0x45 in bits 31:24, the received type-of-service in bits 23:16, and rq_len+20 (16-bit) in bits 15:0. Reply word 1 is the received word 1. Reply word 2 holds TTL 64 in bits 31:24 and the received protocol in bits 23:16.
- R8: Reply word 2 bits 15:0 hold the ones' complement of the ones'-complement sum of the ten 16-bit halves of the reply header, with that field counted as zero.
- R9: While hd_valid is high and hd_ready is low, hd_data and hd_last hold steady. While payload is being forwarded and tp_ready is low, rx_ready is low.
- R10: rq_ready is high only when a header is stored and no reply is in flight. A request accepted on the same clock edge as a new header's fifth word reflects the header stored before that edge.
- R11: A dropped packet leaves the stored header unchanged, so later replies still reflect the last accepted header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive word valid |
| rx_ready | output | 1 | Receive word accepted |
| rx_data | input | 32 | Receive word, header first |
| rx_last | input | 1 | Final word of the packet |
| tp_valid | output | 1 | Payload word valid to the transport handler |
| tp_ready | input | 1 | Transport handler takes the word |
| tp_data | output | 32 | Payload word |
| tp_last | output | 1 | Final payload word |
| rq_valid | input | 1 | Reply header request |
| rq_ready | output | 1 | Request accepted |
| rq_len | input | 16 | Reply payload length in bytes |
| hd_valid | output | 1 | Reply header word valid |
| hd_ready | input | 1 | Reply word taken |
| hd_data | output | 32 | Reply header word |
| hd_last | output | 1 | Fifth reply word |

## Verification
Two events can land on the same clock edge: a reply request is accepted while the fifth word of a new header is being stored. The bench provokes this by driving the last header word and the request in the same cycle. The reply must carry the older header, and the next request must carry the new one. Random back-pressure on both output streams also makes reply word transfers overlap payload forwarding, and the bench checks every word against values computed from its own header model.

// File: rtl/ipr_pkg.sv
package ipr_pkg;

   localparam int unsigned IPR_HDR_WORDS = 5;
   localparam int unsigned IPR_HDR_BYTES = 20;

   // fields of an accepted header that a reply needs
   typedef struct packed {
      logic [7:0]  tos;
      logic [31:0] idfrag;
      logic [7:0]  proto;
      logic [31:0] src;
      logic [31:0] dst;
   } ipr_hdr_t;

endpackage

// File: rtl/ipr_csum.sv
// Ones'-complement checksum over NWORDS words of DW bits.
// csum_o is the complement of the folded 16-bit sum.
module ipr_csum #(
   parameter int unsigned NWORDS = 5,
   parameter int unsigned DW     = 32
) (
   input  logic [NWORDS*DW-1:0] words_i,
   output logic [15:0]          csum_o
);
   localparam int unsigned NH = NWORDS * DW / 16;
   localparam int unsigned SW = 16 + $clog2(NH) + 1;

   if ((DW % 16) != 0) begin : g_bad_width
      $error("ipr_csum: DW must be a multiple of 16");
   end

   logic [SW-1:0] part [NH+1];
   logic [SW-1:0] fold1;
   logic [16:0]   fold2;

   assign part[0] = '0;
   for (genvar i = 0; i < NH; i++) begin : g_acc
      assign part[i+1] = part[i] + SW'(words_i[i*16 +: 16]);
   end

   always_comb begin
      fold1  = SW'(part[NH][15:0]) + SW'(part[NH][SW-1:16]);
      fold2  = 17'(fold1[15:0]) + 17'(fold1[SW-1:16]);
      csum_o = ~fold2[15:0];
   end
endmodule

// File: rtl/ipr_rx_check.sv
// Receive side: collects the header, judges it, steers or drops the payload.
module ipr_rx_check
   import ipr_pkg::*;
#(
   parameter int unsigned DW         = 32,
   parameter logic [7:0]  KEEP_PROTO = 8'd6,
   parameter bit          CHECK_CSUM = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_valid,
   output logic          rx_ready,
   input  logic [DW-1:0] rx_data,
   input  logic          rx_last,
   output logic          tp_valid,
   input  logic          tp_ready,
   output logic [DW-1:0] tp_data,
   output logic          tp_last,
   output ipr_hdr_t      hdr_o,
   output logic          have_hdr_o
);
   localparam int unsigned IDX_W = $clog2(IPR_HDR_WORDS);
   localparam int unsigned NBUF  = IPR_HDR_WORDS - 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(IPR_HDR_WORDS - 1);

   typedef enum logic {S_HDR, S_PAY} st_e;

   st_e              st_q;
   logic [IDX_W-1:0] idx_q;
   logic             keep_q;
   logic [DW-1:0]    hw_q [NBUF];

   logic hdr_beat, pay_beat, at_end;
   logic ver_ok, ihl_ok, proto_ok, sum_ok, all_ok;

   assign rx_ready = (st_q == S_PAY && keep_q) ? tp_ready : 1'b1;
   assign tp_valid = rx_valid && (st_q == S_PAY) && keep_q;
   assign tp_data  = rx_data;
   assign tp_last  = rx_last;

   assign hdr_beat = rx_valid && rx_ready && (st_q == S_HDR);
   assign pay_beat = rx_valid && rx_ready && (st_q == S_PAY);
   assign at_end   = (idx_q == LAST_IDX);

   assign ver_ok   = (hw_q[0][31:28] == 4'd4);
   assign ihl_ok   = (hw_q[0][27:24] == 4'd5);
   assign proto_ok = (hw_q[2][23:16] == KEEP_PROTO);

   if (CHECK_CSUM) begin : g_sum_check
      logic [15:0] resid;
      ipr_csum #(.NWORDS(IPR_HDR_WORDS), .DW(DW)) u_sum (
         .words_i({hw_q[0], hw_q[1], hw_q[2], hw_q[3], rx_data}),
         .csum_o (resid)
      );
      assign sum_ok = (resid == 16'h0000);
   end else begin : g_sum_skip
      assign sum_ok = 1'b1;
   end

   assign all_ok = ver_ok && ihl_ok && proto_ok && sum_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= S_HDR;
         idx_q      <= '0;
         keep_q     <= 1'b0;
         have_hdr_o <= 1'b0;
         hdr_o      <= '0;
         for (int i = 0; i < NBUF; i++) hw_q[i] <= '0;
      end else begin
         if (hdr_beat) begin
            if (!at_end) begin
               for (int i = 0; i < NBUF; i++)
                  if (idx_q == IDX_W'(i)) hw_q[i] <= rx_data;
               idx_q <= rx_last ? '0 : idx_q + 1'b1;
            end else begin
               idx_q <= '0;
               if (!rx_last) begin
                  st_q   <= S_PAY;
                  keep_q <= all_ok;
               end
               if (all_ok) begin
                  have_hdr_o   <= 1'b1;
                  hdr_o.tos    <= hw_q[0][23:16];
                  hdr_o.idfrag <= hw_q[1];
                  hdr_o.proto  <= hw_q[2][23:16];
                  hdr_o.src    <= hw_q[3];
                  hdr_o.dst    <= rx_data;
               end
            end
         end else if (pay_beat && rx_last) begin
            st_q   <= S_HDR;
            keep_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/ipr_reply_build.sv
// Transmit side: reflects the stored header into a five-word reply.
module ipr_reply_build
   import ipr_pkg::*;
#(
   parameter int unsigned DW        = 32,
   parameter int unsigned LEN_W     = 16,
   parameter logic [7:0]  REPLY_TTL = 8'd64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ipr_hdr_t         hdr_i,
   input  logic             have_hdr_i,
   input  logic             rq_valid,
   output logic             rq_ready,
   input  logic [LEN_W-1:0] rq_len,
   output logic             hd_valid,
   input  logic             hd_ready,
   output logic [DW-1:0]    hd_data,
   output logic             hd_last
);
   localparam int unsigned IDX_W = $clog2(IPR_HDR_WORDS);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(IPR_HDR_WORDS - 1);
   localparam int unsigned CSUM_WORD = 2;

   logic [DW-1:0]    cand [IPR_HDR_WORDS];
   logic [DW-1:0]    wq   [IPR_HDR_WORDS];
   logic [15:0]      tlen, csum;
   logic             busy_q;
   logic [IDX_W-1:0] idx_q;

   assign tlen = 16'(rq_len + LEN_W'(IPR_HDR_BYTES));

   always_comb begin
      cand[0] = {4'd4, 4'd5, hdr_i.tos, tlen};
      cand[1] = hdr_i.idfrag;
      cand[2] = {REPLY_TTL, hdr_i.proto, 16'h0000};
      cand[3] = hdr_i.dst;
      cand[4] = hdr_i.src;
   end

   ipr_csum #(.NWORDS(IPR_HDR_WORDS), .DW(DW)) u_sum (
      .words_i({cand[0], cand[1], cand[2], cand[3], cand[4]}),
      .csum_o (csum)
   );

   assign rq_ready = have_hdr_i && !busy_q;
   assign hd_valid = busy_q;
   assign hd_last  = busy_q && (idx_q == LAST_IDX);

   always_comb begin
      hd_data = '0;
      for (int i = 0; i < IPR_HDR_WORDS; i++)
         if (idx_q == IDX_W'(i)) hd_data = wq[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         for (int i = 0; i < IPR_HDR_WORDS; i++) wq[i] <= '0;
      end else if (rq_valid && rq_ready) begin
         busy_q <= 1'b1;
         idx_q  <= '0;
         for (int i = 0; i < IPR_HDR_WORDS; i++)
            wq[i] <= (i == CSUM_WORD) ? {cand[i][DW-1:16], csum} : cand[i];
      end else if (busy_q && hd_ready) begin
         if (idx_q == LAST_IDX) busy_q <= 1'b0;
         else                   idx_q  <= idx_q + 1'b1;
      end
   end
endmodule

// File: rtl/ipr_hdr_proc.sv
module ipr_hdr_proc
   import ipr_pkg::*;
#(
   parameter int unsigned DW         = 32,
   parameter int unsigned LEN_W      = 16,
   parameter logic [7:0]  KEEP_PROTO = 8'd6,
   parameter logic [7:0]  REPLY_TTL  = 8'd64,
   parameter bit          CHECK_CSUM = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_valid,
   output logic             rx_ready,
   input  logic [DW-1:0]    rx_data,
   input  logic             rx_last,
   output logic             tp_valid,
   input  logic             tp_ready,
   output logic [DW-1:0]    tp_data,
   output logic             tp_last,
   input  logic             rq_valid,
   output logic             rq_ready,
   input  logic [LEN_W-1:0] rq_len,
   output logic             hd_valid,
   input  logic             hd_ready,
   output logic [DW-1:0]    hd_data,
   output logic             hd_last
);
   if (DW != 32) begin : g_bad_dw
      $error("ipr_hdr_proc: header words must be 32 bits");
   end
   if (LEN_W != 16) begin : g_bad_len
      $error("ipr_hdr_proc: length field is 16 bits");
   end

   ipr_hdr_t hdr;
   logic     have_hdr;

   ipr_rx_check #(.DW(DW), .KEEP_PROTO(KEEP_PROTO), .CHECK_CSUM(CHECK_CSUM)) u_rx (
      .clk, .rst_n,
      .rx_valid, .rx_ready, .rx_data, .rx_last,
      .tp_valid, .tp_ready, .tp_data, .tp_last,
      .hdr_o(hdr), .have_hdr_o(have_hdr)
   );

   ipr_reply_build #(.DW(DW), .LEN_W(LEN_W), .REPLY_TTL(REPLY_TTL)) u_tx (
      .clk, .rst_n,
      .hdr_i(hdr), .have_hdr_i(have_hdr),
      .rq_valid, .rq_ready, .rq_len,
      .hd_valid, .hd_ready, .hd_data, .hd_last
   );
endmodule

// File: rtl/ipr_hdr_proc_chk.sv
module ipr_hdr_proc_chk #(
   parameter int unsigned DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rx_ready,
   input logic          tp_valid,
   input logic          tp_ready,
   input logic          rq_ready,
   input logic          hd_valid,
   input logic          hd_ready,
   input logic [DW-1:0] hd_data,
   input logic          hd_last
);
   logic [2:0] beat;

   always_ff @(posedge clk) begin
      if (!rst_n)                    beat <= '0;
      else if (hd_valid && hd_ready) beat <= hd_last ? 3'd0 : beat + 3'd1;
   end

   a_r9_hd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      hd_valid && !hd_ready |=> hd_valid && $stable(hd_data) && $stable(hd_last));

   a_r9_tp_stall: assert property (@(posedge clk) disable iff (!rst_n)
      tp_valid && !tp_ready |-> !rx_ready);

   a_r10_rq_idle: assert property (@(posedge clk) disable iff (!rst_n)
      rq_ready |-> !hd_valid);

   a_r6_last_fifth: assert property (@(posedge clk) disable iff (!rst_n)
      hd_valid |-> (hd_last == (beat == 3'd4)));

   a_r7_first_word: assert property (@(posedge clk) disable iff (!rst_n)
      hd_valid && beat == 3'd0 |-> hd_data[31:24] == 8'h45);
endmodule

bind ipr_hdr_proc ipr_hdr_proc_chk #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready),
   .tp_valid(tp_valid), .tp_ready(tp_ready), .rq_ready(rq_ready),
   .hd_valid(hd_valid), .hd_ready(hd_ready), .hd_data(hd_data), .hd_last(hd_last)
);

// File: tb/ipr_hdr_proc_bench.sv
`timescale 1ns/1ps
module ipr_hdr_proc_bench;
   typedef logic [31:0] hw_t [5];

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0, rx_last = 1'b0;
   logic [31:0] rx_data = '0;
   logic        rx_ready;
   logic        tp_valid, tp_last;
   logic [31:0] tp_data;
   logic        tp_ready = 1'b1;
   logic        rq_valid = 1'b0;
   logic [15:0] rq_len = '0;
   logic        rq_ready;
   logic        hd_valid, hd_last;
   logic [31:0] hd_data;
   logic        hd_ready = 1'b1;

   int n_chk = 0;
   int n_fail = 0;

   logic [32:0] tp_got [$];
   logic [32:0] tp_exp [$];
   hw_t         good;
   bit          have_good = 0;

   always #2 clk = ~clk;

   ipr_hdr_proc u_ipr_hdr_proc (
      .clk, .rst_n, .rx_valid, .rx_ready, .rx_data, .rx_last,
      .tp_valid, .tp_ready, .tp_data, .tp_last,
      .rq_valid, .rq_ready, .rq_len,
      .hd_valid, .hd_ready, .hd_data, .hd_last
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] ref_csum(input hw_t h);
      logic [31:0] s = 0;
      for (int i = 0; i < 5; i++) s += 32'(h[i][31:16]) + 32'(h[i][15:0]);
      s = 32'(s[15:0]) + 32'(s[31:16]);
      s = 32'(s[15:0]) + 32'(s[31:16]);
      return ~s[15:0];
   endfunction

   function automatic void mk_hdr(input logic [7:0] proto, output hw_t h);
      h[0] = {8'h45, 8'($urandom), 16'($urandom)};
      h[1] = $urandom;
      h[2] = {8'($urandom), proto, 16'h0};
      h[3] = $urandom;
      h[4] = $urandom;
      h[2][15:0] = ref_csum(h);
   endfunction

   function automatic void mk_reply(input hw_t s, input logic [15:0] len, output hw_t r);
      r[0] = {8'h45, s[0][23:16], 16'(len + 16'd20)};
      r[1] = s[1];
      r[2] = {8'd64, s[2][23:16], 16'h0};
      r[3] = s[4];
      r[4] = s[3];
      r[2][15:0] = ref_csum(r);
   endfunction

   // random back-pressure on both output streams
   always @(posedge clk) begin
      #1;
      tp_ready = ($urandom % 4) != 0;
      hd_ready = ($urandom % 3) != 0;
   end

   logic        hd_stall_prev = 0;
   logic [31:0] hd_prev = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (tp_valid && tp_ready) tp_got.push_back({tp_last, tp_data});
         if (hd_stall_prev)
            chk(hd_valid && hd_data == hd_prev, "R9 reply word held under stall", hd_data, hd_prev);
         if (tp_valid && !tp_ready)
            chk(!rx_ready, "R9 receive stalled with transport", 32'(rx_ready), 32'd0);
         hd_stall_prev = hd_valid && !hd_ready;
         hd_prev = hd_data;
      end
   end

   task automatic rx_put(input logic [31:0] d, input logic l);
      rx_valid = 1'b1; rx_data = d; rx_last = l;
      do @(negedge clk); while (!rx_ready);
      @(posedge clk); #1;
      rx_valid = 1'b0; rx_last = 1'b0;
   endtask

   task automatic rq_put(input logic [15:0] len);
      rq_valid = 1'b1; rq_len = len;
      do @(negedge clk); while (!rq_ready);
      @(posedge clk); #1;
      rq_valid = 1'b0;
   endtask

   task automatic collect(output hw_t got);
      for (int i = 0; i < 5; i++) begin
         do @(negedge clk); while (!(hd_valid && hd_ready));
         got[i] = hd_data;
         chk(hd_last == (i == 4), "R6 last marker on fifth word", 32'(hd_last), 32'(i == 4));
      end
      @(posedge clk); #1;
   endtask

   task automatic check_reply(input hw_t got, input hw_t src, input logic [15:0] len, input string why);
      hw_t e;
      mk_reply(src, len, e);
      chk(got[0] == e[0], {"R7 word0 ", why}, got[0], e[0]);
      chk(got[1] == e[1], {"R7 word1 ", why}, got[1], e[1]);
      chk(got[2][31:16] == e[2][31:16], {"R7 ttl/proto ", why}, got[2], e[2]);
      chk(got[2][15:0] == e[2][15:0], {"R8 checksum ", why}, 32'(got[2][15:0]), 32'(e[2][15:0]));
      chk(got[3] == e[3] && got[4] == e[4], {"R6 swapped addresses ", why}, got[3], e[3]);
   endtask

   task automatic do_reply(input logic [15:0] len, input string why);
      hw_t got;
      rq_put(len);
      collect(got);
      check_reply(got, good, len, why);
   endtask

   task automatic send_pkt(input hw_t h, input int npay, input bit keep, input string tag);
      logic [31:0] d;
      tp_got.delete(); tp_exp.delete();
      for (int i = 0; i < 5; i++) rx_put(h[i], i == 4 && npay == 0);
      for (int j = 0; j < npay; j++) begin
         d = $urandom;
         rx_put(d, j == npay - 1);
         if (keep) tp_exp.push_back({j == npay - 1, d});
      end
      chk(tp_got.size() == tp_exp.size(), {tag, " forwarded word count"}, tp_got.size(), tp_exp.size());
      if (tp_got.size() == tp_exp.size())
         for (int k = 0; k < tp_exp.size(); k++)
            chk(tp_got[k] == tp_exp[k], "R2 payload word", tp_got[k][31:0], tp_exp[k][31:0]);
      if (keep) begin good = h; have_good = 1; end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog expired");
      n_fail++;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      hw_t a, b, c, x;
      void'($urandom(32'd4242));
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!tp_valid, "R1 tp_valid after reset", 32'(tp_valid), 0);
      chk(!hd_valid, "R1 hd_valid after reset", 32'(hd_valid), 0);
      chk(!rq_ready, "R1 rq_ready with no header", 32'(rq_ready), 0);
      @(posedge clk); #1;

      mk_hdr(8'd6, a);
      send_pkt(a, 3, 1, "R2");
      do_reply(16'd100, "first reply");

      // R3 other protocol, R11 stored header kept
      mk_hdr(8'd17, x);
      send_pkt(x, 4, 0, "R3");
      do_reply(16'd7, "R11 after protocol drop");

      // R4 bad version, header length, checksum
      mk_hdr(8'd6, x); x[0][31:28] = 4'd6; x[2][15:0] = 0; x[2][15:0] = ref_csum(x);
      send_pkt(x, 2, 0, "R4 version");
      mk_hdr(8'd6, x); x[0][27:24] = 4'd6; x[2][15:0] = 0; x[2][15:0] = ref_csum(x);
      send_pkt(x, 2, 0, "R4 length");
      mk_hdr(8'd6, x); x[2][0] = ~x[2][0];
      send_pkt(x, 2, 0, "R4 checksum");
      do_reply(16'hFFF0, "R11 after bad headers, length wrap");

      // R5 short packet, then a good one parsed from word 0
      mk_hdr(8'd6, x);
      tp_got.delete();
      rx_put(x[0], 0); rx_put(x[1], 0); rx_put(x[2], 1);
      chk(tp_got.size() == 0, "R5 short packet forwards nothing", tp_got.size(), 0);
      mk_hdr(8'd6, b);
      send_pkt(b, 2, 1, "R5 resync");
      do_reply(16'd0, "R5 new header stored");

      // R10 request and fifth header word on the same edge
      mk_hdr(8'd6, c);
      for (int i = 0; i < 4; i++) rx_put(c[i], 0);
      begin
         hw_t got;
         fork
            rx_put(c[4], 1);
            rq_put(16'd40);
         join
         collect(got);
         check_reply(got, b, 16'd40, "R10 same-edge uses older header");
      end
      good = c;
      do_reply(16'd41, "R10 next request uses new header");

      // random mix
      for (int k = 0; k < 60; k++) begin
         int kind = $urandom % 8;
         int np = $urandom % 5;
         logic [7:0] p = 8'($urandom);
         if (p == 8'd6) p = 8'd17;
         case (kind)
            4: begin mk_hdr(p, x); send_pkt(x, np, 0, "R3 random"); end
            5: begin mk_hdr(8'd6, x); x[0][31:28] = 4'($urandom % 4); x[2][15:0] = 0;
                      x[2][15:0] = ref_csum(x); send_pkt(x, np, 0, "R4 random"); end
            6: begin mk_hdr(8'd6, x); x[2][15] = ~x[2][15]; send_pkt(x, np, 0, "R4 random"); end
            default: begin mk_hdr(8'd6, x); send_pkt(x, np, 1, "R2 random"); end
         endcase
         if (have_good && ($urandom % 2 == 0)) do_reply(16'($urandom), "random");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule